// File: doc/BRIEF.md
# Watchdog Timer with Register Port

The block is a watchdog peripheral. Software sets it up and services it through a small register bus. A down-counter starts when the watchdog is enabled. Software has to restart it at intervals by writing a fixed key value. If the counter runs out first, the block either pulls a system reset output high for a fixed number of cycles, or it first warns software with an interrupt and resets only if the next period also runs out unserviced.

The length of a period is a power of two. A 4-bit index i selects 2^(BASE_EXP+i) clock cycles, where BASE_EXP is 16 by default. One index applies to the first period after enable and a separate index applies to every later reload. Because both indices can be changed at any time, a short boot-time window and a longer steady-state window can be used.

Top module: `wdog_timer`

## Requirements
- R1: After reset the watchdog is disabled, `wdt_irq`, `wdt_rst` and `bus_rvalid` are low, and every register reads 0.
- R2: The control register is at offset 0x00. Bit 0 is the enable and bit 1 is the response mode. A read returns {mode, enable} in bits 1:0, with the upper bits 0.
- R3: The range register is at offset 0x04. Bits 3:0 hold the normal-period index and bits 7:4 hold the first-period index. It reads back as written in bits 7:0.
- R4: Index i means a period of 2^(BASE_EXP+i) cycles. A control write that sets the enable while the watchdog is disabled loads the first-period value. The first expiry becomes visible on the outputs exactly that many cycles after the edge that takes the write.
- R5: A write to offset 0x0C whose bits 7:0 equal 0x76, made while the watchdog is enabled, reloads the counter with the normal period. Every automatic reload after an expiry also uses the normal period.
- R6: A write to offset 0x0C with any other low byte is ignored, and so is any such write made while the watchdog is disabled.
- R7: In mode 0, each expiry drives `wdt_rst` high for exactly RST_CYCLES consecutive cycles.
- R8: In mode 1, an expiry with no interrupt pending raises `wdt_irq` and reloads the counter. An expiry while the interrupt is pending starts the reset pulse.
- R9: A valid restart write clears `wdt_irq`, and so does writing 0 to the enable.
- R10: Writing 0 to the enable stops the counter, and no expiry follows while the watchdog is disabled. Enabling it again reloads the first period.
- R11: Each read request is answered on the next cycle with `bus_rvalid` high. Offset 0x0C and unmapped offsets read 0, and writes to unmapped offsets change nothing.
- R12: A control write that keeps the enable at 1 does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| wdt_irq | output | 1 | Pending first-expiry interrupt (mode 1) |
| wdt_rst | output | 1 | System reset pulse |

## Verification
The hardest case to reach is the second expiry in mode 1 while the interrupt is still pending. It can only occur after two full periods with no valid restart in between, and neither the counter nor the interrupt state can be loaded directly from the ports. The bench therefore builds the block with BASE_EXP set to 3, so that periods last a few dozen cycles. It waits through both periods and times the interval from the interrupt to the reset. Same-cycle orderings, such as a restart write during the last count or an enable rewrite in the middle of a period, are produced by placing bus writes at computed cycle offsets from the enabling write. A behavioural model checks the outputs on every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_RANGE = 'h04;
  localparam int OFS_KICK  = 'h0C;
  localparam logic [7:0] KICK_KEY = 8'h76;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              en_o,
  output logic              mode_o,
  output logic [IDX_W-1:0]  norm_idx_o,
  output logic [IDX_W-1:0]  init_idx_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              kick_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic wr_ctrl, wr_range, wr_kick, rd_req;
  logic wdata_unused;
  logic [DATA_W-1:0] rd_mux;

  assign wdata_unused = ^bus_wdata;
  assign rd_req   = bus_valid && !bus_write;
  assign wr_ctrl  = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_range = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_RANGE));
  assign wr_kick  = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_KICK));

  assign start_o = wr_ctrl && bus_wdata[0] && !en_o;
  assign stop_o  = wr_ctrl && !bus_wdata[0];
  assign kick_o  = wr_kick && (bus_wdata[7:0] == KICK_KEY) && en_o;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      rd_mux[1:0] = {mode_o, en_o};
    end else if (bus_addr == ADDR_W'(OFS_RANGE)) begin
      rd_mux[2*IDX_W-1:0] = {init_idx_o, norm_idx_o};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o       <= 1'b0;
      mode_o     <= 1'b0;
      norm_idx_o <= '0;
      init_idx_o <= '0;
      rdata_o    <= '0;
      rvalid_o   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_o   <= bus_wdata[0];
        mode_o <= bus_wdata[1];
      end
      if (wr_range) begin
        norm_idx_o <= bus_wdata[IDX_W-1:0];
        init_idx_o <= bus_wdata[2*IDX_W-1:IDX_W];
      end
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= rd_mux;
    end
  end

  a_r11_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rvalid_o);
  a_r2_start_enables: assert property (@(posedge clk) disable iff (rst)
    start_o |=> en_o);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W    = 32,
  parameter int IDX_W    = 4,
  parameter int BASE_EXP = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             kick_i,
  input  logic [IDX_W-1:0] norm_idx_i,
  input  logic [IDX_W-1:0] init_idx_i,
  output logic             expire_o
);
  localparam int IDX_N = 1 << IDX_W;

  logic [CNT_W-1:0] reload_tab [IDX_N];
  logic [CNT_W-1:0] cnt_q, norm_val, init_val;

  for (genvar g = 0; g < IDX_N; g++) begin : g_reload
    localparam logic [63:0] PERIOD_M1 = (64'd1 << (BASE_EXP + g)) - 64'd1;
    assign reload_tab[g] = PERIOD_M1[CNT_W-1:0];
  end

  assign norm_val = reload_tab[norm_idx_i];
  assign init_val = reload_tab[init_idx_i];
  assign expire_o = en_i && !start_i && !stop_i && !kick_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= init_val;
    end else if (stop_i) begin
      cnt_q <= cnt_q;
    end else if (kick_i) begin
      cnt_q <= norm_val;
    end else if (en_i) begin
      if (cnt_q == '0) cnt_q <= norm_val;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r4_start_load: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cnt_q == $past(init_val)));
  a_r5_kick_reload: assert property (@(posedge clk) disable iff (rst)
    kick_i |=> (cnt_q == $past(norm_val)));
  a_r10_hold_disabled: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_response.sv
module wdt_response #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic kick_i,
  input  logic stop_i,
  input  logic mode_i,
  output logic irq_o,
  output logic rst_o
);
  localparam int PW = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);

  logic [PW-1:0] pcnt_q;
  logic fire;

  assign fire = expire_i && (!mode_i || irq_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      rst_o  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      if (kick_i || stop_i)                  irq_o <= 1'b0;
      else if (expire_i && mode_i && !irq_o) irq_o <= 1'b1;

      if (fire) begin
        rst_o  <= 1'b1;
        pcnt_q <= PW'(RST_CYCLES - 1);
      end else if (pcnt_q != '0) begin
        pcnt_q <= pcnt_q - 1'b1;
      end else begin
        rst_o <= 1'b0;
      end
    end
  end

  a_r9_irq_cleared: assert property (@(posedge clk) disable iff (rst)
    (kick_i || stop_i) |=> !irq_o);
  a_r8_first_irq: assert property (@(posedge clk) disable iff (rst)
    (expire_i && mode_i && !irq_o) |=> irq_o);
  a_r7_rst_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_o) |-> $past(expire_i));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 32,
  parameter int IDX_W      = 4,
  parameter int BASE_EXP   = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              wdt_irq,
  output logic              wdt_rst
);
  logic en, mode, start, stop, kick, expire;
  logic [IDX_W-1:0] norm_idx, init_idx;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .en_o(en), .mode_o(mode), .norm_idx_o(norm_idx), .init_idx_o(init_idx),
    .start_o(start), .stop_o(stop), .kick_o(kick),
    .rdata_o(bus_rdata), .rvalid_o(bus_rvalid)
  );

  wdt_counter #(.CNT_W(CNT_W), .IDX_W(IDX_W), .BASE_EXP(BASE_EXP)) u_counter (
    .clk(clk), .rst(rst),
    .en_i(en), .start_i(start), .stop_i(stop), .kick_i(kick),
    .norm_idx_i(norm_idx), .init_idx_i(init_idx),
    .expire_o(expire)
  );

  wdt_response #(.RST_CYCLES(RST_CYCLES)) u_response (
    .clk(clk), .rst(rst),
    .expire_i(expire), .kick_i(kick), .stop_i(stop), .mode_i(mode),
    .irq_o(wdt_irq), .rst_o(wdt_rst)
  );
endmodule

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  localparam int BASE = 3;
  localparam int RSTC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bv = 1'b0, bw = 1'b0;
  logic [7:0]  ba = '0;
  logic [31:0] bd = '0;
  logic [31:0] rdata;
  logic rvalid, irq, wrst;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  wdog_timer #(.BASE_EXP(BASE), .RST_CYCLES(RSTC)) i_wdog_timer (
    .clk(clk), .rst(rst), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
    .bus_wdata(bd), .bus_rdata(rdata), .bus_rvalid(rvalid),
    .wdt_irq(irq), .wdt_rst(wrst)
  );

  // behavioural reference model
  int m_en, m_mode, m_norm, m_init, m_irq, m_rst, m_pc, m_rv;
  longint m_cnt;
  int unsigned m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_mode = 0; m_norm = 0; m_init = 0; m_irq = 0;
      m_rst = 0; m_pc = 0; m_rv = 0; m_rd = 0; m_cnt = 0;
    end else begin
      bit wc, wr, wk, st, sp, kk, ex, fi;
      int n_irq;
      wc = bv && bw && ba == 8'h00;
      wr = bv && bw && ba == 8'h04;
      wk = bv && bw && ba == 8'h0C;
      st = wc && bd[0] && m_en == 0;
      sp = wc && !bd[0];
      kk = wk && bd[7:0] == 8'h76 && m_en == 1;
      ex = 0;
      if (st) m_cnt = (64'd1 << (BASE + m_init)) - 1;
      else if (sp) ;
      else if (kk) m_cnt = (64'd1 << (BASE + m_norm)) - 1;
      else if (m_en == 1) begin
        if (m_cnt == 0) begin ex = 1; m_cnt = (64'd1 << (BASE + m_norm)) - 1; end
        else m_cnt--;
      end
      fi = ex && (m_mode == 0 || m_irq == 1);
      n_irq = m_irq;
      if (kk || sp) n_irq = 0;
      else if (ex && m_mode == 1 && m_irq == 0) n_irq = 1;
      m_irq = n_irq;
      if (fi) begin m_rst = 1; m_pc = RSTC - 1; end
      else if (m_pc != 0) m_pc--;
      else m_rst = 0;
      m_rv = bv && !bw;
      if (m_rv) begin
        if (ba == 8'h00) m_rd = {m_mode[0], m_en[0]};
        else if (ba == 8'h04) m_rd = {m_init[3:0], m_norm[3:0]};
        else m_rd = 0;
      end
      if (wc) begin m_en = bd[0]; m_mode = bd[1]; end
      if (wr) begin m_norm = bd[3:0]; m_init = bd[7:4]; end
    end
  end

  task automatic chk(string t, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({tag, " irq"}, irq, m_irq);
      chk({tag, " rst"}, wrst, m_rst);
      chk({tag, " rvalid"}, rvalid, m_rv);
      if (m_rv == 1) chk({tag, " rdata"}, rdata, m_rd);
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bv = 1; bw = 1; ba = a; bd = d;
    @(negedge clk);
    bv = 0; bw = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input string t, input longint exp);
    bv = 1; bw = 0; ba = a;
    @(negedge clk);
    bv = 0;
    chk(t, rvalid, 1);
    chk(t, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cycles_to_rst(output int n);
    n = 0;
    while (!wrst) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int n;
    idle(3);
    chk("R1 irq", irq, 0); chk("R1 rst", wrst, 0); chk("R1 rvalid", rvalid, 0);
    rst = 0;
    idle(1);
    bus_rd(8'h00, "R1 ctrl", 0);
    bus_rd(8'h04, "R1 range", 0);
    tag = "R11";
    bus_rd(8'h0C, "R11 kick reads 0", 0);
    bus_wr(8'h10, 32'hFF);
    bus_rd(8'h10, "R11 unmapped", 0);
    bus_rd(8'h04, "R11 unmapped write ignored", 0);
    tag = "R3";
    bus_wr(8'h04, 32'h21);
    bus_rd(8'h04, "R3 range readback", 32'h21);
    tag = "R2";
    bus_wr(8'h00, 32'h2);
    bus_rd(8'h00, "R2 ctrl readback", 32'h2);
    bus_wr(8'h00, 32'h0);
    tag = "R6";
    bus_wr(8'h0C, 32'h76);
    idle(60);
    chk("R6 kick while disabled", wrst, 0);
    // R4: first period 2^(3+2)=32
    tag = "R4";
    bus_wr(8'h00, 32'h1);
    cycles_to_rst(n);
    chk("R4 first period", n, 32);
    tag = "R7";
    n = 0;
    while (wrst) begin @(negedge clk); n++; end
    chk("R7 pulse width", n, RSTC);
    tag = "R5";
    cycles_to_rst(n);
    chk("R5 auto reload normal period", n, 16 - RSTC);
    idle(8);
    bus_wr(8'h00, 32'h0);
    idle(10);
    // R12: enable rewrite mid-period
    tag = "R12";
    bus_wr(8'h00, 32'h1);
    idle(10);
    bus_wr(8'h00, 32'h1);
    cycles_to_rst(n);
    chk("R12 no reload on rewrite", n, 21);
    bus_wr(8'h00, 32'h0);
    idle(10);
    tag = "R5";
    bus_wr(8'h00, 32'h1);
    idle(10);
    bus_wr(8'h0C, 32'h76);
    cycles_to_rst(n);
    chk("R5 restart reloads normal", n, 16);
    idle(2);
    tag = "R6";
    bus_wr(8'h0C, 32'h75);
    bus_wr(8'h0C, 32'h67);
    idle(30);
    bus_wr(8'h00, 32'h0);
    idle(10);
    // R10: stop mid-count
    tag = "R10";
    bus_wr(8'h00, 32'h1);
    idle(20);
    bus_wr(8'h00, 32'h0);
    n = 0;
    repeat (80) begin @(negedge clk); if (wrst) n++; end
    chk("R10 no expiry while disabled", n, 0);
    bus_wr(8'h00, 32'h1);
    cycles_to_rst(n);
    chk("R10 re-enable loads first period", n, 32);
    bus_wr(8'h00, 32'h0);
    idle(10);
    // R8: mode 1, first 2^4=16, normal 2^3=8
    tag = "R8";
    bus_wr(8'h04, 32'h10);
    bus_wr(8'h00, 32'h3);
    n = 0;
    while (!irq) begin @(negedge clk); n++; end
    chk("R8 irq after first period", n, 16);
    chk("R8 no reset on first expiry", wrst, 0);
    n = 0;
    while (!wrst) begin @(negedge clk); n++; end
    chk("R8 reset after second period", n, 8);
    chk("R8 irq still pending", irq, 1);
    idle(3);
    tag = "R9";
    bus_wr(8'h0C, 32'h76);
    chk("R9 restart clears irq", irq, 0);
    idle(12);
    chk("R9 irq raised again", irq, 1);
    bus_wr(8'h00, 32'h2);
    chk("R9 disable clears irq", irq, 0);
    idle(20);
    tag = "R2";
    bus_wr(8'h00, 32'h1);
    idle(5);
    bus_wr(8'h00, 32'h3);
    bus_rd(8'h00, "R2 mode switch readback", 32'h3);
    idle(40);
    finish_run();
  end
endmodule